// File: doc/BRIEF.md
# Dock instruction ring sequencer

This block is the circular instruction queue of a dock. Instructions arrive from the switch fabric through a valid/ready input at the insertion point. They are shown one at a time at the execution point to a separate execution datapath through a valid/done handshake. The insertion point sits directly behind the execution point in the ring, so the ring works as a FIFO whose tail is the head's neighbour.

After a normal instruction executes, the sequencer acts on its count and requeue fields. Count 0 means the instruction is discarded. A finite count is decremented, and the instruction then either runs again in place or moves to the tail of the ring. The all-ones count marks a standing instruction that never counts down.

Three ring-control instructions never reach the executor. A kill waits at the insertion point and removes the next count+1 instructions that reach the execution point. A clog parks at the execution point and blocks execution. An unclog waits at the insertion point until it meets the clog, and then the two retire together.

Top module: `dock_ring_seq`

## Requirements
- R1: After reset the ring is empty: `in_ready_o`=1, `exec_valid_o`=0 and `free_o`=DEPTH (8).
- R2: An instruction word is {form[24:23], rq[22], count[21:16], body[15:0]}. The form codes are 0 normal, 1 literal, 2 kill and 3 gate; a gate with rq=0 is a clog and with rq=1 an unclog. An executed instruction is shown on `exec_insn_o` bit for bit, including its current count.
- R3: A normal instruction with count 0 is executed once and then leaves the ring, which frees its slot.
- R4: A normal instruction with count c in 1..62 and rq=0 is shown again in place after each execution, with its count lowered by one. It therefore runs c+1 times in a row.
- R5: A normal instruction with count c in 1..62 and rq=1 moves to the tail after it executes, carrying count c-1. It runs again only after every instruction that was already queued behind it.
- R6: A count of 63 is never decremented. Such an instruction repeats in place (rq=0) or requeues (rq=1) without end.
- R7: A literal is executed once and then discarded, whatever its count field holds.
- R8: A kill with count n is held at the insertion point. It removes the next n+1 instructions that reach the execution point without showing them to the executor, and it never removes an instruction whose execution has begun.
- R9: A clog at the execution point is never shown to the executor, and no instruction behind it executes.
- R10: An unclog is held at the insertion point until a clog is at the execution point. Both then retire and execution resumes.
- R11: While a kill or an unclog is held, `in_ready_o` is 0.
- R12: `free_o` reports the number of empty slots. When it is 0, `in_ready_o` is 0 for instructions that need a slot.
- R13: In a cycle where `exec_done_i` causes a requeue, `in_ready_o` is 0: the requeued instruction takes the tail slot ahead of the fabric.
- R14: Once `exec_valid_o` is raised, it stays high with `exec_insn_o` stable until `exec_done_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Fabric offers an instruction |
| in_ready_o | output | 1 | Sequencer takes the offered instruction this cycle |
| in_insn_i | input | 25 | Offered instruction word |
| exec_valid_o | output | 1 | Instruction at the execution point is presented |
| exec_insn_o | output | 25 | Presented instruction, current count included |
| exec_done_i | input | 1 | Executor finished the presented instruction |
| free_o | output | 4 | Number of empty ring slots |

## Verification
The hardest situation to reach from the ports is a kill or unclog that meets a particular instruction at the execution point while the ring behind it is already filled. To set this up, the bench's executor withholds done whenever its scoreboard holds no expected item. The bench first stages instructions in the ring, with the head stalled in execution. It then inserts the kill or unclog, and only after that queues the expected executions. From that point the ordering of repeats, requeues and removals shows up as the sequence of presented words, and the final state shows up in `free_o`.

// File: rtl/dock_ring_pkg.sv
package dock_ring_pkg;
  localparam int CNT_W  = 6;
  localparam int BODY_W = 16;

  typedef enum logic [1:0] {
    FORM_NORMAL  = 2'd0,
    FORM_LITERAL = 2'd1,
    FORM_KILL    = 2'd2,
    FORM_GATE    = 2'd3
  } form_e;

  typedef struct packed {
    form_e             form;
    logic              rq;   // gate form: 0 clog, 1 unclog
    logic [CNT_W-1:0]  cnt;
    logic [BODY_W-1:0] body;
  } insn_t;

  localparam int INSN_W = $bits(insn_t);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
endpackage

// File: rtl/dock_ring_store.sv
module dock_ring_store
  import dock_ring_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         push_i,
  input  insn_t                        push_data_i,
  input  logic                         pop_i,
  input  logic                         upd_i,
  input  insn_t                        upd_data_i,
  output insn_t                        head_o,
  output logic                         empty_o,
  output logic                         full_o,
  output logic [$clog2(DEPTH+1)-1:0]   used_o
);
  localparam int PTR_W  = $clog2(DEPTH);
  localparam int USED_W = $clog2(DEPTH+1);

  insn_t             mem_q [DEPTH];
  logic [PTR_W-1:0]  rd_q, wr_q;
  logic [USED_W-1:0] used_q;

  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= push_data_i;
    if (upd_i)  mem_q[rd_q] <= upd_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q   <= '0;
      wr_q   <= '0;
      used_q <= '0;
    end else begin
      if (push_i) wr_q <= step_ptr(wr_q);
      if (pop_i)  rd_q <= step_ptr(rd_q);
      unique case ({push_i, pop_i})
        2'b10:   used_q <= used_q + 1'b1;
        2'b01:   used_q <= used_q - 1'b1;
        default: used_q <= used_q;
      endcase
    end
  end

  assign head_o  = mem_q[rd_q];
  assign empty_o = (used_q == '0);
  assign full_o  = (used_q == USED_W'(DEPTH));
  assign used_o  = used_q;

  // R12
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (!full_o || pop_i));
  // R3
  pop_frees_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i) |=> (used_o == $past(used_o) - 1'b1));
endmodule

// File: rtl/dock_ring_step.sv
module dock_ring_step
  import dock_ring_pkg::*;
(
  input  insn_t head_i,
  output logic  retire_o,
  output logic  requeue_o,
  output logic  upd_o,
  output insn_t next_o
);
  logic standing;

  always_comb begin
    standing  = (head_i.cnt == CNT_MAX);
    next_o    = head_i;
    retire_o  = 1'b0;
    requeue_o = 1'b0;
    upd_o     = 1'b0;
    if (!standing) next_o.cnt = head_i.cnt - 1'b1;
    if (head_i.form == FORM_LITERAL || head_i.cnt == '0) begin
      retire_o = 1'b1;
    end else if (head_i.rq) begin
      requeue_o = 1'b1;
    end else begin
      upd_o = !standing;
    end
  end
endmodule

// File: rtl/dock_ring_hold.sv
module dock_ring_hold
  import dock_ring_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kill_load_i,
  input  logic             unclog_load_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             kill_fire_i,
  input  logic             unclog_fire_i,
  output logic             kill_active_o,
  output logic             unclog_active_o
);
  logic             kill_q, unclog_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kill_q   <= 1'b0;
      unclog_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      if (kill_load_i) begin
        kill_q <= 1'b1;
        cnt_q  <= load_cnt_i;
      end else if (kill_fire_i) begin
        if (cnt_q == '0) kill_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end
      if (unclog_load_i)      unclog_q <= 1'b1;
      else if (unclog_fire_i) unclog_q <= 1'b0;
    end
  end

  assign kill_active_o   = kill_q;
  assign unclog_active_o = unclog_q;

  // R8
  kill_countdown_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_fire_i && cnt_q != '0) |=> (kill_q && cnt_q == $past(cnt_q) - 1'b1));
  // R8
  kill_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_q && !kill_fire_i) |=> (kill_q && $stable(cnt_q)));
endmodule

// File: rtl/dock_ring_seq.sv
module dock_ring_seq
  import dock_ring_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       in_valid_i,
  output logic                       in_ready_o,
  input  logic [INSN_W-1:0]          in_insn_i,
  output logic                       exec_valid_o,
  output logic [INSN_W-1:0]          exec_insn_o,
  input  logic                       exec_done_i,
  output logic [$clog2(DEPTH+1)-1:0] free_o
);
  localparam int USED_W = $clog2(DEPTH+1);

  insn_t             in_w, head, next_w, push_data;
  logic              empty, full, busy_q;
  logic [USED_W-1:0] used;
  logic              kill_active, unclog_active;
  logic              st_retire, st_requeue, st_upd;
  logic              head_exec, head_clog, done, requeue_now;
  logic              in_is_kill, in_is_unclog, in_is_ctrl, accept;
  logic              kill_fire, unclog_fire, push, pop, upd;

  assign in_w         = insn_t'(in_insn_i);
  assign in_is_kill   = (in_w.form == FORM_KILL);
  assign in_is_unclog = (in_w.form == FORM_GATE) && in_w.rq;
  assign in_is_ctrl   = in_is_kill || in_is_unclog;

  assign head_exec = !empty && (head.form == FORM_NORMAL || head.form == FORM_LITERAL);
  assign head_clog = !empty && (head.form == FORM_GATE) && !head.rq;

  assign exec_valid_o = busy_q || (head_exec && !kill_active);
  assign exec_insn_o  = head;
  assign done         = exec_valid_o && exec_done_i;
  assign requeue_now  = done && st_requeue;

  // kill acts only on an instruction not yet handed to the executor
  assign kill_fire   = kill_active && !busy_q && !empty && !head_clog;
  assign unclog_fire = unclog_active && head_clog;

  assign in_ready_o = !kill_active && !unclog_active && !requeue_now &&
                      (!full || in_is_ctrl);
  assign accept     = in_valid_i && in_ready_o;

  assign push      = requeue_now || (accept && !in_is_ctrl);
  assign push_data = requeue_now ? next_w : in_w;
  assign pop       = (done && (st_retire || st_requeue)) || kill_fire || unclog_fire;
  assign upd       = done && st_upd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= exec_valid_o && !exec_done_i;
  end

  dock_ring_store #(.DEPTH(DEPTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .upd_i       (upd),
    .upd_data_i  (next_w),
    .head_o      (head),
    .empty_o     (empty),
    .full_o      (full),
    .used_o      (used)
  );

  dock_ring_step u_step (
    .head_i    (head),
    .retire_o  (st_retire),
    .requeue_o (st_requeue),
    .upd_o     (st_upd),
    .next_o    (next_w)
  );

  dock_ring_hold u_hold (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .kill_load_i     (accept && in_is_kill),
    .unclog_load_i   (accept && in_is_unclog),
    .load_cnt_i      (in_w.cnt),
    .kill_fire_i     (kill_fire),
    .unclog_fire_i   (unclog_fire),
    .kill_active_o   (kill_active),
    .unclog_active_o (unclog_active)
  );

  assign free_o = USED_W'(DEPTH) - used;

  // R14
  exec_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_valid_o && !exec_done_i) |=> (exec_valid_o && $stable(exec_insn_o)));
  // R9
  clog_blocks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_clog |-> !exec_valid_o);
  // R6
  standing_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && head.form == FORM_NORMAL && head.cnt == CNT_MAX && !head.rq)
      |=> (!empty && head == $past(head)));
  // R10
  unclog_meet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unclog_active && head_clog) |=> !unclog_active);
  // R11
  hold_blocks_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_active || unclog_active) |-> !accept);
endmodule

// File: tb/dock_ring_seq_tb.sv
module dock_ring_seq_tb;
  import dock_ring_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              in_valid = 1'b0;
  logic              in_ready;
  logic [INSN_W-1:0] in_insn = '0;
  logic              exec_valid;
  logic [INSN_W-1:0] exec_insn;
  logic              exec_done = 1'b0;
  logic [3:0]        free_cnt;

  int total = 0;
  int bad   = 0;
  logic [INSN_W-1:0] exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dock_ring_seq u_dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .in_valid_i   (in_valid),
    .in_ready_o   (in_ready),
    .in_insn_i    (in_insn),
    .exec_valid_o (exec_valid),
    .exec_insn_o  (exec_insn),
    .exec_done_i  (exec_done),
    .free_o       (free_cnt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [INSN_W-1:0] mk(input logic [1:0] f, input logic rq,
                                           input logic [5:0] c, input logic [15:0] b);
    return {f, rq, c, b};
  endfunction

  task automatic send(input logic [INSN_W-1:0] w);
    logic r;
    @(negedge clk);
    in_valid = 1'b1;
    in_insn  = w;
    do begin
      #(CLK_PERIOD/2 - 1);
      r = in_ready;
      @(posedge clk);
    end while (!r);
    #1 in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // scoreboard monitor / executor: done only while an item is expected
  initial begin
    forever begin
      @(negedge clk);
      exec_done = 1'b0;
      if (rst_n && exec_valid && exp_q.size() > 0) begin
        logic [INSN_W-1:0] e;
        e = exp_q.pop_front();
        chk("R2 exec word", 32'(exec_insn), 32'(e));
        exec_done = 1'b1;
        #1;
        if (e[24:23] == 2'd0 && e[22] && e[21:16] != 6'd0)
          chk("R13 ready low on requeue", 32'(in_ready), 32'd0);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [INSN_W-1:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 ready", 32'(in_ready), 32'd1);
    chk("R1 valid", 32'(exec_valid), 32'd0);
    chk("R1 free", 32'(free_cnt), 32'd8);

    // R3 single shot
    exp_q.push_back(mk(2'd0, 1'b0, 6'd0, 16'h1111));
    send(mk(2'd0, 1'b0, 6'd0, 16'h1111));
    wait_idle();
    chk("R3 free", 32'(free_cnt), 32'd8);
    chk("R3 valid", 32'(exec_valid), 32'd0);

    // R4 repeat in place
    for (int c = 2; c >= 0; c--) exp_q.push_back(mk(2'd0, 1'b0, 6'(c), 16'h2222));
    send(mk(2'd0, 1'b0, 6'd2, 16'h2222));
    wait_idle();
    chk("R4 free", 32'(free_cnt), 32'd8);

    // R5 requeue goes behind queued work
    send(mk(2'd0, 1'b1, 6'd1, 16'h3333));
    send(mk(2'd0, 1'b0, 6'd0, 16'h4444));
    exp_q.push_back(mk(2'd0, 1'b1, 6'd1, 16'h3333));
    exp_q.push_back(mk(2'd0, 1'b0, 6'd0, 16'h4444));
    exp_q.push_back(mk(2'd0, 1'b1, 6'd0, 16'h3333));
    wait_idle();
    chk("R5 free", 32'(free_cnt), 32'd8);

    // R6 standing, repeat in place, then kill it
    s = mk(2'd0, 1'b0, 6'd63, 16'h5555);
    repeat (3) exp_q.push_back(s);
    send(s);
    wait_idle();
    chk("R6 standing held", 32'(exec_insn), 32'(s));
    repeat (3) @(negedge clk);
    chk("R14 stable", 32'(exec_insn), 32'(s));
    chk("R14 valid", 32'(exec_valid), 32'd1);
    send(mk(2'd2, 1'b0, 6'd0, 16'h0));
    chk("R11 kill blocks", 32'(in_ready), 32'd0);
    exp_q.push_back(s);
    wait_idle();
    chk("R8 standing killed", 32'(free_cnt), 32'd8);
    chk("R8 valid", 32'(exec_valid), 32'd0);

    // R6 standing with requeue
    s = mk(2'd0, 1'b1, 6'd63, 16'h6666);
    send(s);
    send(mk(2'd0, 1'b0, 6'd0, 16'h7777));
    exp_q.push_back(s);
    exp_q.push_back(mk(2'd0, 1'b0, 6'd0, 16'h7777));
    exp_q.push_back(s);
    exp_q.push_back(s);
    wait_idle();
    chk("R6 requeue standing", 32'(exec_insn), 32'(s));
    chk("R6 ring", 32'(free_cnt), 32'd7);
    send(mk(2'd2, 1'b0, 6'd0, 16'h0));
    exp_q.push_back(s);
    wait_idle();
    chk("R8 free", 32'(free_cnt), 32'd8);

    // R7 literal
    exp_q.push_back(mk(2'd1, 1'b0, 6'd5, 16'h8888));
    send(mk(2'd1, 1'b0, 6'd5, 16'h8888));
    wait_idle();
    chk("R7 free", 32'(free_cnt), 32'd8);
    chk("R7 valid", 32'(exec_valid), 32'd0);

    // R8 kill count 1 removes two after the running one
    for (int i = 1; i <= 4; i++) send(mk(2'd0, 1'b0, 6'd0, 16'(16'hA0 + i)));
    send(mk(2'd2, 1'b0, 6'd1, 16'h0));
    chk("R11 kill held", 32'(in_ready), 32'd0);
    exp_q.push_back(mk(2'd0, 1'b0, 6'd0, 16'hA1));
    wait_idle();
    chk("R8 survivor", 32'(exec_insn), 32'(mk(2'd0, 1'b0, 6'd0, 16'hA4)));
    chk("R8 count", 32'(free_cnt), 32'd7);
    exp_q.push_back(mk(2'd0, 1'b0, 6'd0, 16'hA4));
    wait_idle();

    // R9 / R10 clog and unclog
    send(mk(2'd3, 1'b0, 6'd0, 16'h0));
    send(mk(2'd0, 1'b0, 6'd0, 16'hB1));
    exp_q.push_back(mk(2'd0, 1'b0, 6'd0, 16'hB1));
    repeat (5) @(negedge clk);
    chk("R9 blocked", 32'(exec_valid), 32'd0);
    chk("R9 pending", 32'(exp_q.size()), 32'd1);
    chk("R9 ring", 32'(free_cnt), 32'd6);
    send(mk(2'd3, 1'b1, 6'd0, 16'h0));
    wait_idle();
    chk("R10 resumed", 32'(free_cnt), 32'd8);

    // R12 full ring with requeue at head
    send(mk(2'd0, 1'b1, 6'd1, 16'hC0));
    for (int i = 1; i <= 7; i++) send(mk(2'd0, 1'b0, 6'd0, 16'(16'hC0 + i)));
    @(negedge clk);
    chk("R12 free zero", 32'(free_cnt), 32'd0);
    chk("R12 ready low", 32'(in_ready), 32'd0);
    exp_q.push_back(mk(2'd0, 1'b1, 6'd1, 16'hC0));
    for (int i = 1; i <= 7; i++) exp_q.push_back(mk(2'd0, 1'b0, 6'd0, 16'(16'hC0 + i)));
    exp_q.push_back(mk(2'd0, 1'b1, 6'd0, 16'hC0));
    wait_idle();
    chk("R12 drained", 32'(free_cnt), 32'd8);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule